// File: doc/BRIEF.md
# Dual-Queue Transmit Descriptor Ring Walker

This block is the transmit side of a small network controller's DMA. Software builds two circular rings of transmit descriptors in memory, one for a high-priority queue and one for a low-priority queue. It programs the head address of each ring and then writes a command word to start one or both queues. The engine then walks the chosen ring exactly once. It reads each descriptor over a word-wide request/response memory port. When a descriptor belongs to hardware, the engine fetches the frame buffer and sends it byte by byte on a valid/ready stream. It then hands the descriptor back to software by writing the status word with the owner bit cleared, and it records a per-queue cause bit.

A descriptor occupies 16 bytes and is made of four little-endian words. The walk finishes when the next pointer of the descriptor just handled equals the programmed head. Descriptors that software still owns are stepped over. A level interrupt reports causes that are enabled in a mask register. The interrupt is re-evaluated when a command finishes or when the mask is written, and it drops as soon as no enabled cause remains.

Top module: `tx_ring_dma`

## Requirements
- R1: A descriptor at byte address D holds four words. D+0 is status, where bit 31 set means hardware owns it. D+4 carries the byte count in bits 31:16. D+8 holds the buffer address and D+12 the next-descriptor address. Buffer words are sent least significant byte first.
- R2: Register writes use cfg_addr 0 for the low head, 1 for the high head, 2 for the command, 3 for the mask and 4 for the cause. Command bit 23 starts the high queue and bit 22 starts the low queue. With both set, the high ring is walked to completion before the low ring. A command with neither bit starts nothing.
- R3: A walk starts at the head and follows the next pointers. It ends after the descriptor whose next pointer equals the head.
- R4: A descriptor whose status bit 31 is clear produces no stream bytes, no memory write and no cause bit.
- R5: An owned descriptor with a byte count from 1 to 2047 emits exactly that many bytes, with tx_last on the final one. A count of 0 or of 2048 and above emits nothing.
- R6: Every owned descriptor has its status word rewritten at D+0, with bit 31 cleared and bits 30:0 unchanged, whether or not bytes were sent.
- R7: Each owned descriptor of the low queue sets cause bit 3, and each one of the high queue sets cause bit 2. A write to the cause register ANDs the written value into it. Cause bits never set on their own.
- R8: When a command finishes or the mask is written, irq becomes 1 if cause AND mask is nonzero. At other times irq can only fall, and it falls in the cycle in which cause AND mask becomes zero.
- R9: busy is 1 from the cycle after an accepted start command until the last walk ends. While busy, writes to the command and head registers are ignored.
- R10: mem_req, mem_addr, mem_we and mem_wdata are held until mem_ack. tx_data and tx_last are held while tx_valid waits for tx_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Frame byte available |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |
| busy | output | 1 | A ring walk is in progress |
| cause | output | 4 | Cause bits (3 low queue, 2 high queue) |
| irq | output | 1 | Interrupt request |

## Verification
The low ring mixes owned and unowned descriptors with short odd and even counts. This separates skipping from stopping, and it shows the byte order inside each buffer word. The high ring puts counts of 2048, 1 and 2047 next to each other to probe the send limit from both sides. It is started together with the low queue, which checks the order of service and that each queue sets its own cause bit. A single self-linked descriptor and a ring with no owned descriptors cover the shortest walk and the walk that has no effect at all. Head and command writes issued mid-walk, followed by a restart, show that they were dropped. The memory acknowledge and stream ready are stalled pseudo-randomly throughout.

// File: rtl/tx_ring_dma.sv
module tx_ring_dma #(
  parameter int AW      = 32,
  parameter int MAX_LEN = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          busy,
  output logic [3:0]    cause,
  output logic          irq
);

  localparam logic [2:0] A_HEAD_LO = 3'd0;
  localparam logic [2:0] A_HEAD_HI = 3'd1;
  localparam logic [2:0] A_CMD     = 3'd2;
  localparam logic [2:0] A_MASK    = 3'd3;
  localparam logic [2:0] A_CAUSE   = 3'd4;
  localparam int CMD_HI = 23;
  localparam int CMD_LO = 22;
  localparam int OWN    = 31;
  localparam logic [15:0] LEN_LIMIT = 16'(MAX_LEN);

  typedef enum logic [3:0] {
    S_IDLE, S_PICK, S_RD_STAT, S_RD_LEN, S_RD_BUF, S_RD_NEXT,
    S_FETCH, S_SEND, S_WB, S_ADV
  } state_t;

  state_t        state;
  logic [AW-1:0] head_lo, head_hi, cur, nxt, bufp;
  logic          pend_hi, pend_lo, qsel;
  logic [31:0]   stat, word;
  logic [15:0]   len, remain;
  logic [1:0]    bidx;
  logic [3:0]    cause_q, mask_q;
  logic          irq_q;

  wire idle     = (state == S_IDLE);
  wire wr_head  = cfg_we && idle;
  wire cmd_wr   = cfg_we && cfg_addr == A_CMD && idle;
  wire start    = cmd_wr && (cfg_wdata[CMD_HI] || cfg_wdata[CMD_LO]);
  wire mask_wr  = cfg_we && cfg_addr == A_MASK;
  wire cause_wr = cfg_we && cfg_addr == A_CAUSE;
  wire done     = (state == S_PICK) && !pend_hi && !pend_lo;
  wire send_ok  = (len != 16'd0) && (len < LEN_LIMIT);
  wire [AW-1:0] cur_head = qsel ? head_hi : head_lo;

  assign busy      = !idle;
  assign mem_req   = (state == S_RD_STAT) || (state == S_RD_LEN) || (state == S_RD_BUF) ||
                     (state == S_RD_NEXT) || (state == S_FETCH) || (state == S_WB);
  assign mem_we    = (state == S_WB);
  assign mem_wdata = {1'b0, stat[30:0]};
  assign tx_valid  = (state == S_SEND);
  assign tx_data   = word[8*bidx +: 8];
  assign tx_last   = (remain == 16'd1);
  assign cause     = cause_q;
  assign irq       = irq_q;

  always_comb begin
    case (state)
      S_RD_LEN:  mem_addr = cur + AW'(4);
      S_RD_BUF:  mem_addr = cur + AW'(8);
      S_RD_NEXT: mem_addr = cur + AW'(12);
      S_FETCH:   mem_addr = bufp;
      S_RD_STAT, S_WB: mem_addr = cur;
      default:   mem_addr = '0;
    endcase
  end

  logic [3:0] set_bits, cause_n, mask_n;
  logic       pend_irq;
  always_comb begin
    set_bits = '0;
    if (state == S_WB && mem_ack) set_bits = qsel ? 4'b0100 : 4'b1000;
    cause_n  = (cause_wr ? (cause_q & cfg_wdata[3:0]) : cause_q) | set_bits;
    mask_n   = mask_wr ? cfg_wdata[3:0] : mask_q;
    pend_irq = |(cause_n & mask_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_lo <= '0;
      head_hi <= '0;
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_head && cfg_addr == A_HEAD_LO) head_lo <= cfg_wdata[AW-1:0];
      if (wr_head && cfg_addr == A_HEAD_HI) head_hi <= cfg_wdata[AW-1:0];
      cause_q <= cause_n;
      mask_q  <= mask_n;
      irq_q   <= (done || mask_wr) ? pend_irq : (irq_q && pend_irq);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pend_hi <= 1'b0;
      pend_lo <= 1'b0;
      qsel    <= 1'b0;
      cur     <= '0;
      nxt     <= '0;
      bufp    <= '0;
      stat    <= '0;
      word    <= '0;
      len     <= '0;
      remain  <= '0;
      bidx    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pend_hi <= cfg_wdata[CMD_HI];
          pend_lo <= cfg_wdata[CMD_LO];
          state   <= S_PICK;
        end
        S_PICK: begin
          if (pend_hi) begin
            qsel <= 1'b1; pend_hi <= 1'b0; cur <= head_hi; state <= S_RD_STAT;
          end else if (pend_lo) begin
            qsel <= 1'b0; pend_lo <= 1'b0; cur <= head_lo; state <= S_RD_STAT;
          end else begin
            state <= S_IDLE;
          end
        end
        S_RD_STAT: if (mem_ack) begin
          stat  <= mem_rdata;
          state <= mem_rdata[OWN] ? S_RD_LEN : S_RD_NEXT;
        end
        S_RD_LEN: if (mem_ack) begin
          len   <= mem_rdata[31:16];
          state <= S_RD_BUF;
        end
        S_RD_BUF: if (mem_ack) begin
          bufp  <= mem_rdata[AW-1:0];
          state <= S_RD_NEXT;
        end
        S_RD_NEXT: if (mem_ack) begin
          nxt <= mem_rdata[AW-1:0];
          if (!stat[OWN])   state <= S_ADV;
          else if (send_ok) begin
            remain <= len;
            state  <= S_FETCH;
          end else          state <= S_WB;
        end
        S_FETCH: if (mem_ack) begin
          word  <= mem_rdata;
          bufp  <= bufp + AW'(4);
          bidx  <= '0;
          state <= S_SEND;
        end
        S_SEND: if (tx_ready) begin
          remain <= remain - 16'd1;
          if (remain == 16'd1)  state <= S_WB;
          else if (bidx == 2'd3) state <= S_FETCH;
          else                  bidx <= bidx + 2'd1;
        end
        S_WB: if (mem_ack) state <= S_ADV;
        S_ADV: begin
          if (nxt == cur_head) state <= S_PICK;
          else begin
            cur   <= nxt;
            state <= S_RD_STAT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_wb_owner_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[OWN]);

  p_irq_needs_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(cause & mask_q));

  p_cause_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cause[3] && !cause_wr |=> cause[3]);

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cfg_we && cfg_addr == A_CMD && (cfg_wdata[CMD_HI] || cfg_wdata[CMD_LO]) |=> busy);

endmodule

// File: tb/tx_ring_dma_bench.sv
module tx_ring_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        busy, irq;
  logic [3:0]  cause;

  always #5 clk = ~clk;

  tx_ring_dma u_tx_ring_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .busy(busy), .cause(cause), .irq(irq));

  logic [31:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[11:2]];

  int errors = 0;
  int checks = 0;
  int exp_tx[$];
  logic [31:0] exp_wa[$], exp_wd[$];
  int exp_wq[$];
  logic [3:0] exp_cause = '0, exp_mask = '0;
  logic exp_irq = 1'b0;
  logic run = 1'b0, prev_busy = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic c_tx = 0, c_txl = 0, c_wr = 0, c_cfg = 0;
  logic [7:0] c_txd = 0;
  logic [31:0] c_wa = 0, c_wd = 0, c_cd = 0;
  logic [2:0] c_ca = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] st, input int len,
                     input logic [31:0] bp, input logic [31:0] nx);
    mem[a[11:2]]       = st;
    mem[a[11:2] + 10'd1] = {len[15:0], 16'hBEEF};
    mem[a[11:2] + 10'd2] = bp;
    mem[a[11:2] + 10'd3] = nx;
  endtask

  task automatic model_walk(input logic [31:0] head, input int qi);
    logic [31:0] cur, st, bp, nx;
    int n;
    cur = head;
    do begin
      st = mem[cur[11:2]];
      n  = int'(mem[cur[11:2] + 10'd1] >> 16);
      bp = mem[cur[11:2] + 10'd2];
      nx = mem[cur[11:2] + 10'd3];
      if (st[31]) begin
        if (n > 0 && n < 2048)
          for (int i = 0; i < n; i++)
            exp_tx.push_back(((i == n - 1) ? 256 : 0) + int'(byte_at(bp + 32'(i))));
        exp_wa.push_back(cur);
        exp_wd.push_back(st & 32'h7FFF_FFFF);
        exp_wq.push_back(qi);
      end
      cur = nx;
    end while (cur != head);
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic wait_idle(input string tag);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_tx.size() == 0, tag, "bytes still expected", 32'(exp_tx.size()), 0);
    chk(exp_wa.size() == 0, tag, "writebacks still expected", 32'(exp_wa.size()), 0);
  endtask

  task automatic low_ring();
    put(32'h100, 32'h8000_0011, 5, 32'h400, 32'h110);
    put(32'h110, 32'h0000_0022, 6, 32'h480, 32'h120);
    put(32'h120, 32'h8000_0033, 8, 32'h500, 32'h100);
  endtask

  always @(posedge clk) begin
    c_tx  <= tx_valid && tx_ready;
    c_txd <= tx_data;
    c_txl <= tx_last;
    c_wr  <= mem_req && mem_we && mem_ack;
    c_wa  <= mem_addr;
    c_wd  <= mem_wdata;
    c_cfg <= cfg_we;
    c_ca  <= cfg_addr;
    c_cd  <= cfg_wdata;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
  end

  always @(negedge clk) begin
    logic mask_ev;
    int e;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ack  = mem_req && (lfsr[1:0] != 2'b00);
    tx_ready = (lfsr[4:3] != 2'b00);
    if (run) begin
      mask_ev = 1'b0;
      if (c_cfg && c_ca == 3'd4) exp_cause = exp_cause & c_cd[3:0];
      if (c_cfg && c_ca == 3'd3) begin exp_mask = c_cd[3:0]; mask_ev = 1'b1; end
      if (c_wr) begin
        if (exp_wa.size() == 0) chk(1'b0, "R4", "unexpected write", c_wa, 0);
        else begin
          chk(c_wa == exp_wa[0], "R3", "writeback address", c_wa, exp_wa[0]);
          chk(c_wd == exp_wd[0], "R6", "writeback status", c_wd, exp_wd[0]);
          exp_cause = exp_cause | ((exp_wq[0] == 1) ? 4'b0100 : 4'b1000);
          void'(exp_wa.pop_front()); void'(exp_wd.pop_front()); void'(exp_wq.pop_front());
        end
      end
      if (c_tx) begin
        if (exp_tx.size() == 0) chk(1'b0, "R5", "unexpected byte", {23'd0, c_txl, c_txd}, 0);
        else begin
          e = exp_tx.pop_front();
          chk({c_txl, c_txd} == 9'(e), "R1/R5", "stream byte and last", {23'd0, c_txl, c_txd}, 32'(e));
        end
      end
      if (mask_ev || (prev_busy && !busy)) exp_irq = |(exp_cause & exp_mask);
      else exp_irq = exp_irq && |(exp_cause & exp_mask);
      chk(cause == exp_cause, "R7", "cause bits", {28'd0, cause}, {28'd0, exp_cause});
      chk(irq == exp_irq, "R8", "irq level", {31'd0, irq}, {31'd0, exp_irq});
    end
    prev_busy = busy;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h9E37_79B9 * 32'(i + 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !tx_valid, "R9", "reset quiet", {29'd0, busy, mem_req, tx_valid}, 0);
    chk(cause == 4'd0 && !irq, "R8", "reset cause/irq", {27'd0, irq, cause}, 0);
    run = 1'b1;

    // low ring, mask off: cause bit 3 only, irq stays low
    low_ring();
    cfg_write(3'd0, 32'h100);
    cfg_write(3'd3, 32'h0);
    model_walk(32'h100, 0);
    cfg_write(3'd2, 32'h0040_0000);
    chk(busy, "R9", "busy after start", {31'd0, busy}, 1);
    wait_idle("R3");
    chk(cause == 4'b1000, "R7", "low queue sets bit 3", {28'd0, cause}, 32'h8);
    chk(!irq, "R8", "masked cause keeps irq low", {31'd0, irq}, 0);
    cfg_write(3'd3, 32'h8);
    @(negedge clk);
    chk(irq, "R8", "mask write raises irq", {31'd0, irq}, 1);
    cfg_write(3'd4, 32'h0);
    @(negedge clk);
    chk(!irq && cause == 0, "R7", "cause AND clear", {27'd0, irq, cause}, 0);

    // command with neither start bit
    cfg_write(3'd2, 32'hFF3F_FFFF);
    repeat (3) @(negedge clk);
    chk(!busy, "R2", "no start bit leaves idle", {31'd0, busy}, 0);

    // both queues: high first; writes while busy ignored
    low_ring();
    put(32'h200, 32'h8000_1234, 2048, 32'h600, 32'h210);
    put(32'h210, 32'h8000_0001, 1, 32'h700, 32'h220);
    put(32'h220, 32'h8000_0002, 2047, 32'h800, 32'h200);
    put(32'h340, 32'h8000_0077, 3, 32'h780, 32'h340);
    cfg_write(3'd1, 32'h200);
    cfg_write(3'd3, 32'h4);
    model_walk(32'h200, 1);
    model_walk(32'h100, 0);
    cfg_write(3'd2, 32'h00C0_0000);
    cfg_write(3'd0, 32'h340);
    cfg_write(3'd2, 32'h0040_0000);
    wait_idle("R2");
    chk(cause == 4'b1100, "R7", "both cause bits", {28'd0, cause}, 32'hC);
    chk(irq, "R8", "irq at walk end", {31'd0, irq}, 1);
    cfg_write(3'd4, 32'h0);

    // restart low: head write during busy must have been dropped
    low_ring();
    model_walk(32'h100, 0);
    cfg_write(3'd2, 32'h0040_0000);
    wait_idle("R9");

    // self-linked single descriptor
    cfg_write(3'd4, 32'h0);
    put(32'h300, 32'h8000_0044, 4, 32'h440, 32'h300);
    cfg_write(3'd0, 32'h300);
    model_walk(32'h300, 0);
    cfg_write(3'd2, 32'h0040_0000);
    wait_idle("R3");

    // ring with no owned descriptors
    put(32'h380, 32'h0000_0055, 3, 32'h460, 32'h390);
    put(32'h390, 32'h0000_0066, 3, 32'h460, 32'h380);
    cfg_write(3'd1, 32'h380);
    cfg_write(3'd2, 32'h0080_0000);
    chk(busy, "R9", "busy during empty walk", {31'd0, busy}, 1);
    wait_idle("R4");
    chk(cause == 4'b1000, "R4", "unowned ring sets no cause", {28'd0, cause}, 32'h8);
    chk(mem[10'h0E0] == 32'h0000_0055, "R4", "unowned status untouched", mem[10'h0E0], 32'h55);

    run = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule